// File: doc/BRIEF.md
# CPU Bus Glue and Address Decoder

This block sits between a 16-bit processor bus with a 24-bit byte address space and the memories and peripherals around it. The processor has no byte address line 0. It presents word address lines 23..1, an active-low address strobe, active-low upper and lower data strobes, and a read/write line. The block turns these into one chip select per device:

- paired program ROM,
- paired byte-wide RAM with per-lane enables,
- an 8-bit parallel I/O device,
- a dual UART,
- a 16-bit IDE port,
- an expansion window.

It also produces shared active-low read and write strobes for peripherals that expect that signalling. The acknowledge line is held low, so every bus cycle completes with zero wait states.

The address space is split on byte address bit 23. The upper half belongs to RAM. The lower half is cut into eight 1 MB slots by bits 22..20. Each device image is repeated through its whole slot. The parallel I/O device has four registers, and its register index is taken from address lines 2..1. Byte address 0x100006 therefore reaches register 3.

A free-running counter divides the 16 MHz input clock. The divided processor clock is 16, 8, 4, 2 or 1 MHz, chosen by a select input.

Top module: `cpu_bus_glue`

## Requirements
- R1: With the address strobe low, byte addresses select devices as follows:
  - 0x000000–0x0FFFFF: ROM
  - 0x100000–0x1FFFFF: parallel I/O
  - 0x200000–0x2FFFFF: UART
  - 0x300000–0x3FFFFF: IDE
  - 0x400000–0x7FFFFF: expansion
  - 0x800000–0xFFFFFF: RAM

  Every chip select is active low.
- R2: While the address strobe is high, every chip select is high. At no time is more than one of rom_cs_n_o, pio_cs_n_o, uart_cs_n_o, ide_cs_n_o, exp_cs_n_o, ram_cs_n_o low.
- R3: ram_ub_n_o equals uds_n_i and ram_lb_n_o equals lds_n_i while ram_cs_n_o is low. Both are high otherwise.
- R4: rd_n_o is low exactly when the address strobe is low, rw_i is 1 and at least one data strobe is low.
- R5: wr_n_o is low exactly when the address strobe is low, rw_i is 0 and at least one data strobe is low. rd_n_o and wr_n_o are never low together.
- R6: pio_reg_o equals address lines 2..1. For example, byte address 0x100006 gives 3.
- R7: dtack_n_o is low at all times.
- R8: clk_sel_i values 0, 1, 2, 3 and 4 give cpu_clk_o equal to clk_i divided by 1, 2, 4, 8 and 16. Values 5 to 7 divide by 16.
  - The divider is a 4-bit counter that is 0 in reset and increments on every rising clk_i edge after reset.
  - For select k from 1 to 4, cpu_clk_o is counter bit k-1.
  - For select 0, cpu_clk_o follows clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16 MHz source clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 3 | Processor clock divider select |
| addr_i | input | 23 | Word address lines 23..1 |
| as_n_i | input | 1 | Address strobe, active low |
| uds_n_i | input | 1 | Upper data strobe, active low |
| lds_n_i | input | 1 | Lower data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| rom_cs_n_o | output | 1 | Program ROM pair select |
| ram_cs_n_o | output | 1 | RAM pair select |
| ram_ub_n_o | output | 1 | RAM upper (even) byte lane enable |
| ram_lb_n_o | output | 1 | RAM lower (odd) byte lane enable |
| pio_cs_n_o | output | 1 | Parallel I/O select |
| pio_reg_o | output | 2 | Parallel I/O register index |
| uart_cs_n_o | output | 1 | Dual UART select |
| ide_cs_n_o | output | 1 | IDE port select |
| exp_cs_n_o | output | 1 | Expansion window select |
| rd_n_o | output | 1 | Peripheral read strobe |
| wr_n_o | output | 1 | Peripheral write strobe |
| dtack_n_o | output | 1 | Transfer acknowledge |
| cpu_clk_o | output | 1 | Divided processor clock |

## Verification
The decoder is exercised by a sweep of all sixteen 1 MB slots. The sweep uses addresses at the start, middle and end of each slot, so a wrong bit slice or a wrong slot boundary shows up as a select on the wrong side of an edge. Each address is driven with every combination of read/write, upper strobe, lower strobe and address strobe. These combinations separate the read and write strobes, check the gating by the address strobe, and confirm that the RAM lane enables follow the data strobes. The divider is run under every select value, including the three out-of-range codes, and its output is compared against an independent count of clock edges since reset.

// File: rtl/cpu_glue_pkg.sv
package cpu_glue_pkg;

    localparam int ADDR_MSB   = 23;
    localparam int REGION_LSB = 20;
    localparam int SLOT_BITS  = 3;
    localparam int NUM_SLOTS  = 1 << SLOT_BITS;
    localparam int DIV_W      = 4;

    typedef enum logic [2:0] {
        SLOT_ROM  = 3'd0,
        SLOT_PIO  = 3'd1,
        SLOT_UART = 3'd2,
        SLOT_IDE  = 3'd3
    } slot_e;

    typedef struct packed {
        logic rom;
        logic pio;
        logic uart;
        logic ide;
        logic exp;
        logic ram;
    } dev_sel_t;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

endpackage

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
    import cpu_glue_pkg::*;
(
    input  logic [ADDR_MSB:1] addr_i,
    input  logic              as_n_i,
    output dev_sel_t          sel_o
);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 low_half;

    assign low_half = ~addr_i[ADDR_MSB];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_hit[s] = low_half &&
            (addr_i[REGION_LSB+SLOT_BITS-1:REGION_LSB] == SLOT_BITS'(s));
    end

    always_comb begin
        sel_o      = '0;
        sel_o.rom  = slot_hit[SLOT_ROM];
        sel_o.pio  = slot_hit[SLOT_PIO];
        sel_o.uart = slot_hit[SLOT_UART];
        sel_o.ide  = slot_hit[SLOT_IDE];
        sel_o.exp  = |slot_hit[NUM_SLOTS-1:4];
        sel_o.ram  = addr_i[ADDR_MSB];
        if (as_n_i) begin
            sel_o = '0;
        end
    end

endmodule

// File: rtl/glue_strobe_gen.sv
module glue_strobe_gen (
    input  logic as_n_i,
    input  logic uds_n_i,
    input  logic lds_n_i,
    input  logic rw_i,
    input  logic ram_sel_i,
    output logic rd_n_o,
    output logic wr_n_o,
    output logic ram_ub_n_o,
    output logic ram_lb_n_o
);

    logic xfer;

    always_comb begin
        xfer       = ~as_n_i && (~uds_n_i || ~lds_n_i);
        rd_n_o     = ~(xfer && rw_i);
        wr_n_o     = ~(xfer && ~rw_i);
        ram_ub_n_o = ram_sel_i ? uds_n_i : 1'b1;
        ram_lb_n_o = ram_sel_i ? lds_n_i : 1'b1;
    end

endmodule

// File: rtl/glue_clk_div.sv
module glue_clk_div
    import cpu_glue_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             cpu_clk_o
);

    div_state_t state_d;
    div_state_t state_q;

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (sel_i == '0) begin
            cpu_clk_o = clk_i;
        end else if (int'(sel_i) >= DIV_W) begin
            cpu_clk_o = state_q.cnt[DIV_W-1];
        end else begin
            cpu_clk_o = state_q.cnt[int'(sel_i) - 1];
        end
    end

endmodule

// File: rtl/cpu_bus_glue.sv
module cpu_bus_glue
    import cpu_glue_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [SEL_W-1:0]  clk_sel_i,
    input  logic [ADDR_MSB:1] addr_i,
    input  logic              as_n_i,
    input  logic              uds_n_i,
    input  logic              lds_n_i,
    input  logic              rw_i,
    output logic              rom_cs_n_o,
    output logic              ram_cs_n_o,
    output logic              ram_ub_n_o,
    output logic              ram_lb_n_o,
    output logic              pio_cs_n_o,
    output logic [1:0]        pio_reg_o,
    output logic              uart_cs_n_o,
    output logic              ide_cs_n_o,
    output logic              exp_cs_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              dtack_n_o,
    output logic              cpu_clk_o
);

    dev_sel_t sel;

    glue_addr_decode u_dec (
        .addr_i (addr_i),
        .as_n_i (as_n_i),
        .sel_o  (sel)
    );

    glue_strobe_gen u_stb (
        .as_n_i     (as_n_i),
        .uds_n_i    (uds_n_i),
        .lds_n_i    (lds_n_i),
        .rw_i       (rw_i),
        .ram_sel_i  (sel.ram),
        .rd_n_o     (rd_n_o),
        .wr_n_o     (wr_n_o),
        .ram_ub_n_o (ram_ub_n_o),
        .ram_lb_n_o (ram_lb_n_o)
    );

    glue_clk_div #(.SEL_W(SEL_W)) u_div (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .sel_i     (clk_sel_i),
        .cpu_clk_o (cpu_clk_o)
    );

    assign rom_cs_n_o  = ~sel.rom;
    assign ram_cs_n_o  = ~sel.ram;
    assign pio_cs_n_o  = ~sel.pio;
    assign uart_cs_n_o = ~sel.uart;
    assign ide_cs_n_o  = ~sel.ide;
    assign exp_cs_n_o  = ~sel.exp;
    assign pio_reg_o   = addr_i[2:1];
    assign dtack_n_o   = 1'b0;

endmodule

// File: rtl/cpu_bus_glue_chk.sv
module cpu_bus_glue_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic [SEL_W-1:0] clk_sel_i,
    input logic             as_n_i,
    input logic             uds_n_i,
    input logic             lds_n_i,
    input logic             rom_cs_n_o,
    input logic             ram_cs_n_o,
    input logic             ram_ub_n_o,
    input logic             ram_lb_n_o,
    input logic             pio_cs_n_o,
    input logic             uart_cs_n_o,
    input logic             ide_cs_n_o,
    input logic             exp_cs_n_o,
    input logic             rd_n_o,
    input logic             wr_n_o,
    input logic             cpu_clk_o
);

    logic [5:0] cs_act;
    assign cs_act = ~{rom_cs_n_o, ram_cs_n_o, pio_cs_n_o,
                      uart_cs_n_o, ide_cs_n_o, exp_cs_n_o};

    // R2
    single_select_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0(cs_act));

    // R2
    idle_no_select_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        as_n_i |-> (cs_act == '0));

    // R3
    ram_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !ram_cs_n_o |-> (ram_ub_n_o == uds_n_i && ram_lb_n_o == lds_n_i));

    // R5
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(!rd_n_o && !wr_n_o));

    // R4
    idle_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        as_n_i |-> (rd_n_o && wr_n_o));

    // R8
    half_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clk_sel_i == SEL_W'(1) && $past(clk_sel_i) == SEL_W'(1) && $past(rst_n_i))
            |-> (cpu_clk_o != $past(cpu_clk_o)));

endmodule

bind cpu_bus_glue cpu_bus_glue_chk #(.SEL_W(SEL_W)) chk_i (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .clk_sel_i   (clk_sel_i),
    .as_n_i      (as_n_i),
    .uds_n_i     (uds_n_i),
    .lds_n_i     (lds_n_i),
    .rom_cs_n_o  (rom_cs_n_o),
    .ram_cs_n_o  (ram_cs_n_o),
    .ram_ub_n_o  (ram_ub_n_o),
    .ram_lb_n_o  (ram_lb_n_o),
    .pio_cs_n_o  (pio_cs_n_o),
    .uart_cs_n_o (uart_cs_n_o),
    .ide_cs_n_o  (ide_cs_n_o),
    .exp_cs_n_o  (exp_cs_n_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .cpu_clk_o   (cpu_clk_o)
);

// File: tb/cpu_bus_glue_tb_top.sv
`timescale 1ns/1ps
module cpu_bus_glue_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_sel = 3'd1;
    logic [23:1] addr = '0;
    logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
    logic rom_cs_n, ram_cs_n, ram_ub_n, ram_lb_n, pio_cs_n, uart_cs_n;
    logic ide_cs_n, exp_cs_n, rd_n, wr_n, dtack_n, cpu_clk;
    logic [1:0] pio_reg;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cpu_bus_glue dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .clk_sel_i(clk_sel), .addr_i(addr),
        .as_n_i(as_n), .uds_n_i(uds_n), .lds_n_i(lds_n), .rw_i(rw),
        .rom_cs_n_o(rom_cs_n), .ram_cs_n_o(ram_cs_n), .ram_ub_n_o(ram_ub_n),
        .ram_lb_n_o(ram_lb_n), .pio_cs_n_o(pio_cs_n), .pio_reg_o(pio_reg),
        .uart_cs_n_o(uart_cs_n), .ide_cs_n_o(ide_cs_n), .exp_cs_n_o(exp_cs_n),
        .rd_n_o(rd_n), .wr_n_o(wr_n), .dtack_n_o(dtack_n), .cpu_clk_o(cpu_clk)
    );

    // reference edge count since reset release
    always @(posedge clk) begin
        if (rst_n) edges <= edges + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
        end
    endtask

    // compare every output against the reference on each falling edge
    always @(negedge clk) begin
        if (!done) begin
            int unsigned a;
            logic [5:0] exp_cs;
            logic xfer, e_clk;
            int k;
            a = {8'h00, addr, 1'b0};
            exp_cs = 6'b000000;
            if (!as_n) begin
                if (a >= 32'h800000)      exp_cs = 6'b000001;
                else if (a < 32'h100000)  exp_cs = 6'b100000;
                else if (a < 32'h200000)  exp_cs = 6'b010000;
                else if (a < 32'h300000)  exp_cs = 6'b001000;
                else if (a < 32'h400000)  exp_cs = 6'b000100;
                else                      exp_cs = 6'b000010;
            end
            // R1 R2: order rom,pio,uart,ide,exp,ram
            chk("R1", "selects", ~{rom_cs_n, pio_cs_n, uart_cs_n, ide_cs_n,
                                  exp_cs_n, ram_cs_n}, exp_cs);
            // R3
            chk("R3", "ram lanes", {4'b0, ram_ub_n, ram_lb_n},
                exp_cs[0] ? {4'b0, uds_n, lds_n} : 6'b000011);
            xfer = !as_n && (!uds_n || !lds_n);
            // R4 R5
            chk("R4", "rd_n", {5'b0, rd_n}, {5'b0, !(xfer && rw)});
            chk("R5", "wr_n", {5'b0, wr_n}, {5'b0, !(xfer && !rw)});
            // R6
            chk("R6", "pio_reg", {4'b0, pio_reg}, {4'b0, addr[2:1]});
            // R7
            chk("R7", "dtack_n", {5'b0, dtack_n}, 6'b0);
            // R8
            k = (clk_sel > 3'd4) ? 4 : int'(clk_sel);
            e_clk = (k == 0) ? 1'b0 : 1'((edges % 16) >> (k - 1));
            chk("R8", "cpu_clk", {5'b0, cpu_clk}, {5'b0, e_clk});
        end
    end

    task automatic cycle(input logic [23:0] byte_addr, input logic r,
                         input logic u, input logic l);
        @(posedge clk); #1;
        addr = byte_addr[23:1]; rw = r; uds_n = 1'b1; lds_n = 1'b1; as_n = 1'b1;
        @(posedge clk); #1;
        as_n = 1'b0;
        @(posedge clk); #1;
        uds_n = u; lds_n = l;
        @(posedge clk); #1;
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                @(negedge clk); @(negedge clk);
                rst_n = 1'b1;
                // R1 R2 R3 R4 R5: sweep slots, offsets and strobe patterns
                for (int s = 0; s < 16; s++) begin
                    for (int o = 0; o < 3; o++) begin
                        logic [23:0] ba;
                        ba = {s[3:0], 20'h0} + ((o == 0) ? 24'h0 :
                             (o == 1) ? 24'h7_1236 : 24'hF_FFFE);
                        for (int p = 0; p < 8; p++) begin
                            cycle(ba, p[2], p[1], p[0]);
                        end
                    end
                end
                // R6: control register of the parallel device
                cycle(24'h100006, 1'b0, 1'b1, 1'b0);
                // R8: every divider select including out-of-range codes
                for (int s = 0; s < 8; s++) begin
                    @(posedge clk); #1;
                    clk_sel = s[2:0];
                    repeat (40) @(posedge clk);
                end
                clk_sel = 3'd2;
                repeat (4) @(posedge clk);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule